// File: doc/BRIEF.md
# Register-Armed Watchdog Reset Timer

This block is a watchdog that sits on a simple register-write port and runs on the peripheral bus clock. Software arms it by writing a nonzero limit into its only writable register. That write clears an internal up-counter, which then advances by one per clock toward the limit. Writing zero disarms the watchdog, and no reset follows. Writing another nonzero value while it runs restarts the count from zero toward the new limit, so one register acts as enable, limit and kick together.

If software does not return in time, the counter reaches the limit. The block then drives two active-low reset outputs low together, one for the peripherals and one for the whole system. They stay low for a fixed, parameterised number of clocks. The block then returns to the idle state with the limit register reading zero. A read port always shows the limit register, and a status output shows whether the counter is running.

Top module: `wdog_reset_timer`

## Requirements
- R1: While `rstN` is low at a clock edge, the block clears. From that edge on, `rdData` is 0, `running` is 0 and both `periRstN` and `sysRstN` are 1. Without writes the block then stays idle indefinitely.
- R2: After a write is accepted (`wrEn` high at a rising edge outside a reset pulse), `rdData` shows the written value. `running` is 1 if that value is nonzero.
- R3: On expiry, `periRstN` and `sysRstN` fall in the same cycle, and they stay equal throughout the pulse.
- R4: A zero write accepted while armed makes `running` 0. No reset pulse follows.
- R5: If a nonzero value N is accepted at edge E, the reset outputs are first low after edge E+N, provided no later write intervenes. A nonzero write while armed restarts the count from zero with the new value as the limit.
- R6: The reset outputs stay low for exactly PULSE_LEN clocks (default 16), then return to 1. From the expiry edge on, `rdData` reads 0, and after the pulse `running` is 0.
- R7: Writes during the reset pulse are ignored. The pulse length is unchanged, `rdData` stays 0 and the block is idle afterwards.
- R8: A write accepted on the edge at which expiry would occur takes priority. No pulse is generated, and the written value reloads or disarms the counter.
- R9: Asserting `rstN` during a pulse returns both reset outputs to 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rstN | input | 1 | Synchronous active-low block reset |
| wrEn | input | 1 | Write strobe for the limit register |
| wrData | input | 32 | Value to write |
| rdData | output | 32 | Current limit register contents |
| running | output | 1 | High while the counter is armed |
| periRstN | output | 1 | Active-low peripheral reset pulse |
| sysRstN | output | 1 | Active-low system reset pulse |

## Verification
The embedded properties check on every cycle the following. A pulse starts only from an armed counter that hits its limit with no write pending. A write outside a pulse never leads into one. A zero write always disarms. The count never runs past the limit while incrementing. A pulse is never cut short except by reset. Only the bench scenarios show the absolute figures: the exact expiry latency for several limits, the restart latency after a mid-count kick, the full pulse length, and the cleared readback after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_PULSE = 2'd2
  } wdState_t;

  typedef struct packed {
    logic loadTarget;
    logic clearTarget;
    logic clearCount;
    logic incCount;
  } wdStrobes_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdStrobes_t    st,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] target,
  output logic          hit,
  output logic          wrIsZero
);
  logic [DW-1:0] count;
  logic [DW-1:0] countNext;

  assign countNext = count + DW'(1);
  assign hit       = (countNext == target);
  assign wrIsZero  = (wrData == '0);

  always_ff @(posedge clk) begin
    if (!rstN)               target <= '0;
    else if (st.loadTarget)  target <= wrData;
    else if (st.clearTarget) target <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (st.clearCount) count <= '0;
    else if (st.incCount)   count <= countNext;
  end

  // R5: incrementing only ever happens strictly below the limit
  assert_cnt_below_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.incCount |-> (count < target));
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrIsZero,
  input  logic       hit,
  output wdStrobes_t st,
  output logic       armed,
  output logic       inPulse
);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PULSE_LEN - 1);

  wdState_t state, stateNext;
  logic [PW-1:0] pulseCnt;

  always_comb begin
    stateNext = state;
    st = '0;
    case (state)
      WD_IDLE, WD_ARMED: begin
        if (wrEn) begin
          st.loadTarget = 1'b1;
          st.clearCount = 1'b1;
          stateNext = wrIsZero ? WD_IDLE : WD_ARMED;
        end else if (state == WD_ARMED) begin
          if (hit) begin
            st.clearTarget = 1'b1;
            st.clearCount  = 1'b1;
            stateNext = WD_PULSE;
          end else begin
            st.incCount = 1'b1;
          end
        end
      end
      WD_PULSE: begin
        if (pulseCnt == PLAST) stateNext = WD_IDLE;
      end
      default: stateNext = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= WD_IDLE;
      pulseCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == WD_PULSE) pulseCnt <= pulseCnt + PW'(1);
      else                   pulseCnt <= '0;
    end
  end

  assign armed   = (state == WD_ARMED);
  assign inPulse = (state == WD_PULSE);

  // R3: a pulse only begins from an armed count hitting its limit without a write
  assert_pulse_from_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inPulse) |-> $past(armed && hit && !wrEn));

  // R8: an accepted write never leads into a pulse
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inPulse) |=> !inPulse);

  // R4: a zero write always leaves the block idle
  assert_zero_disarms_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIsZero && !inPulse) |=> (!armed && !inPulse));

  // R7: the pulse is not cut short by writes
  assert_pulse_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inPulse && pulseCnt != PLAST) |=> inPulse);
endmodule

// File: rtl/wdog_reset_timer.sv
module wdog_reset_timer
  import wdog_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          running,
  output logic          periRstN,
  output logic          sysRstN
);
  wdStrobes_t st;
  logic hit, wrIsZero, inPulse;

  wdog_datapath #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .target(rdData), .hit(hit), .wrIsZero(wrIsZero)
  );

  wdog_control #(.PULSE_LEN(PULSE_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIsZero(wrIsZero), .hit(hit),
    .st(st), .armed(running), .inPulse(inPulse)
  );

  assign periRstN = ~inPulse;
  assign sysRstN  = ~inPulse;

  // R6: the limit register reads zero throughout a pulse
  assert_cleared_in_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    inPulse |-> (rdData == '0 && !running));
endmodule

// File: tb/tb_wdog_reset_timer.sv
module tb_wdog_reset_timer;
  localparam int PL = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic running, periRstN, sysRstN;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_reset_timer #(.DW(32), .PULSE_LEN(PL)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .running(running), .periRstN(periRstN), .sysRstN(sysRstN)
  );

  localparam int NVEC = 5;
  localparam int unsigned VEC_N [NVEC] = '{1, 2, 5, 17, 40};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive a write that is accepted at the next rising edge; return at the negedge after it.
  task automatic doWrite(input logic [31:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitExpiry(output int cyc, input int lim);
    cyc = 0;
    while (periRstN && cyc < lim) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic measurePulse(inout int low);
    while (!periRstN && low < 1000) begin
      @(negedge clk);
      if (!periRstN) low++;
    end
  endtask

  task automatic sysReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int cyc;
    int low;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rdData == 0 && !running, "R1 reset rdData/running", rdData, 0);
    chk(periRstN && sysRstN, "R1 reset outputs high", {periRstN, sysRstN}, 3);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    chk(periRstN && !running, "R1 idle without writes", {periRstN, running}, 2);

    // Vector table: expiry latency, pulse shape and cleanup
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC_N[i]);
      chk(rdData == VEC_N[i] && running, "R2 readback after write", rdData, VEC_N[i]);
      waitExpiry(cyc, 1000);
      chk(cyc == int'(VEC_N[i]), "R5 expiry latency", cyc, VEC_N[i]);
      chk(periRstN == sysRstN, "R3 both resets together", {periRstN, sysRstN}, 0);
      chk(rdData == 0, "R6 register cleared at expiry", rdData, 0);
      low = 1;
      measurePulse(low);
      chk(low == PL, "R6 pulse length", low, PL);
      chk(!running && sysRstN, "R6 idle after pulse", running, 0);
    end

    // R4: zero write disarms
    doWrite(32'd6);
    repeat (3) @(negedge clk);
    doWrite(32'd0);
    chk(!running && rdData == 0, "R4 zero write disarms", running, 0);
    waitExpiry(cyc, 40);
    chk(cyc == 40 && periRstN, "R4 no reset after disarm", cyc, 40);

    // R5: restart mid-count
    doWrite(32'd10);
    repeat (5) @(negedge clk);
    doWrite(32'd4);
    waitExpiry(cyc, 100);
    chk(cyc == 4, "R5 restart latency", cyc, 4);
    low = 1;
    measurePulse(low);

    // R8: write on the expiry edge takes priority (reload)
    doWrite(32'd3);
    repeat (2) @(negedge clk);
    doWrite(32'd7);
    chk(periRstN && running && rdData == 7, "R8 write beats expiry", periRstN, 1);
    waitExpiry(cyc, 100);
    chk(cyc == 7, "R8 reload latency", cyc, 7);
    low = 1;
    measurePulse(low);

    // R8: zero write on the expiry edge disarms
    doWrite(32'd3);
    repeat (2) @(negedge clk);
    doWrite(32'd0);
    waitExpiry(cyc, 30);
    chk(cyc == 30 && !running, "R8 zero write on expiry edge", cyc, 30);

    // R7: writes during the pulse are ignored
    doWrite(32'd2);
    waitExpiry(cyc, 100);
    low = 1;
    doWrite(32'd9);
    if (!periRstN) low++;
    chk(rdData == 0, "R7 write ignored in pulse", rdData, 0);
    measurePulse(low);
    chk(low == PL, "R7 pulse length with write", low, PL);
    chk(!running && rdData == 0, "R7 idle after pulse", rdData, 0);

    // R9: reset during pulse
    doWrite(32'd2);
    waitExpiry(cyc, 100);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(periRstN && sysRstN, "R9 reset ends pulse", {periRstN, sysRstN}, 3);
    rstN = 1'b1;
    repeat (PL + 2) @(negedge clk);
    chk(periRstN && !running && rdData == 0, "R9 stays idle", rdData, 0);
    sysReset();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule